// File: doc/BRIEF.md
# Pixel Hit Timing Counter (Time-over-Threshold and Time-of-Arrival)

This block sits behind the discriminator of a single pixel and turns its binary hit signal into two small timing words during an acquisition window. One word counts how many acquisition-clock ticks the first hit stays above threshold (Time-over-Threshold). The other counts the ticks from the first threshold crossing until the window closes (Time-of-Arrival). A late hit therefore gives a small arrival value and an early hit a large one. A calibration mode replaces timing with a plain count of crossings. Both words and a hit flag are held once the window closes, so that a frame readout can collect them afterwards.

The core runs on a fast system clock. The acquisition clock is modelled as a tick enable, and the enable is high only while the acquisition is running. The hit input is asynchronous to the ticks. It passes through a two-stage synchroniser, clocked on ticks, before edges are detected. A rising edge of the shutter opens a new window and clears the previous frame's data.

Top module: `hit_timer_top`

## Requirements
- R1: While rstN is low (asynchronous, active low), totVal, toaVal and hitFlag are 0.
- R2: In timing mode (modeCount = 0), totVal equals the number of active ticks (tickEn = 1 and shutter = 1) during which the synchronised hit stays high in the first pulse of the window. Later pulses in the same window do not change it.
- R3: totVal and toaVal saturate at 15 and never wrap.
- R4: In timing mode, toaVal equals the number of active ticks from the tick where the first rising edge is recorded through the last active tick of the window. Later rising edges do not restart it.
- R5: While shutter is low, totVal, toaVal and hitFlag hold their values, and hit pulses have no effect on them.
- R6: On cycles with tickEn = 0, neither the counters nor the synchroniser advance. A hit pulse lying entirely within such cycles is never recorded.
- R7: In counting mode (modeCount = 1), totVal equals the number of rising edges of the hit in the window, saturating at 15, and toaVal stays 0.
- R8: hitFlag is 1 exactly when a rising edge has been recorded in the current window. It equals (totVal != 0 or toaVal != 0).
- R9: A rising edge of shutter clears totVal, toaVal and hitFlag to 0 on that clock edge.
- R10: The hit passes through two tick-clocked flops. With tickEn held at 1, a hit first sampled high at active tick D after the window opens (the opening tick is 0) and a window of L ticks gives toaVal = min(L - D - 2, 15).
- R11: A hit that is already high when the window opens is not recorded until it falls and rises again inside the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Acquisition-clock tick enable |
| shutter | input | 1 | Acquisition window, high while acquiring |
| modeCount | input | 1 | 0 = timing mode, 1 = crossing-count calibration mode |
| hitIn | input | 1 | Discriminator output, asynchronous |
| totVal | output | 4 | Time-over-Threshold value, or crossing count in calibration mode |
| toaVal | output | 4 | Time-of-Arrival value |
| hitFlag | output | 1 | A hit was recorded in the current window |

## Verification
Trains of several pulses are applied. A design that lets a later pulse restart or extend the timing would report the last pulse's width or a shorter arrival time. Pulses longer than 15 ticks, and early hits in long windows, push both counters to their limit, so a wrapping counter would read back small values. A hit held high across the window opening, and a pulse hidden in tick-disabled cycles, must leave all outputs at zero. Pulses after the shutter falls must leave the stored frame untouched. Counting mode is driven past 15 crossings to show saturation and a zero arrival word.

// File: rtl/hit_timer_pkg.sv
package hit_timer_pkg;
  localparam int CNT_W = 4;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic clr;      // window opens: clear all
    logic totLoad;  // first rise: tot <= 1
    logic totInc;   // tot saturating increment
    logic toaLoad;  // first rise: toa <= 1
    logic toaInc;   // toa saturating increment
    logic flagSet;  // a rise was recorded
  } strobe_t;
endpackage

// File: rtl/hit_timer_satcnt.sv
module hit_timer_satcnt #(
  parameter int Width = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             load,
  input  logic             inc,
  output logic [Width-1:0] q
);
  localparam logic [Width-1:0] MaxVal = {Width{1'b1}};
  localparam logic [Width-1:0] OneVal = {{(Width-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else if (load) begin
      q <= OneVal;
    end else if (inc && (q != MaxVal)) begin
      q <= q + OneVal;
    end
  end
endmodule

// File: rtl/hit_timer_ctrl.sv
module hit_timer_ctrl
  import hit_timer_pkg::*;
#(
  parameter int SyncStages = SYNC_STAGES
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickEn,
  input  logic    shutter,
  input  logic    modeCount,
  input  logic    hitIn,
  output strobe_t strb
);
  logic [SyncStages-1:0] syncQ;
  logic hitS, hitPrev, shutPrev;
  logic seen, totRun;
  logic active, openWin, riseTick, firstRise;

  // Tick-clocked synchroniser chain
  genvar gi;
  generate
    for (gi = 0; gi < SyncStages; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else if (tickEn) syncQ[0] <= hitIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else if (tickEn) syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign hitS = syncQ[SyncStages-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitPrev  <= 1'b0;
      shutPrev <= 1'b0;
    end else begin
      shutPrev <= shutter;
      if (tickEn) hitPrev <= hitS;
    end
  end

  assign active    = tickEn & shutter;
  assign openWin   = shutter & ~shutPrev;
  assign riseTick  = active & hitS & ~hitPrev & ~openWin;
  assign firstRise = riseTick & ~seen & ~modeCount;

  always_comb begin
    strb         = '0;
    strb.clr     = openWin;
    strb.totLoad = firstRise;
    strb.toaLoad = firstRise;
    strb.flagSet = riseTick;
    strb.totInc  = active & ~openWin &
                   ((modeCount & riseTick) | (~modeCount & totRun & hitS));
    strb.toaInc  = active & ~openWin & ~modeCount & seen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen   <= 1'b0;
      totRun <= 1'b0;
    end else if (openWin) begin
      seen   <= 1'b0;
      totRun <= 1'b0;
    end else if (active && !modeCount) begin
      if (firstRise) begin
        seen   <= 1'b1;
        totRun <= 1'b1;
      end else if (totRun && !hitS) begin
        totRun <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hit_timer_dp.sv
module hit_timer_dp
  import hit_timer_pkg::*;
#(
  parameter int CntW = CNT_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  output logic [CntW-1:0] totVal,
  output logic [CntW-1:0] toaVal,
  output logic            hitFlag
);
  hit_timer_satcnt #(.Width(CntW)) u_tot (
    .clk (clk),
    .rstN(rstN),
    .clr (strb.clr),
    .load(strb.totLoad),
    .inc (strb.totInc),
    .q   (totVal)
  );

  hit_timer_satcnt #(.Width(CntW)) u_toa (
    .clk (clk),
    .rstN(rstN),
    .clr (strb.clr),
    .load(strb.toaLoad),
    .inc (strb.toaInc),
    .q   (toaVal)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hitFlag <= 1'b0;
    else if (strb.clr) hitFlag <= 1'b0;
    else if (strb.flagSet) hitFlag <= 1'b1;
  end
endmodule

// File: rtl/hit_timer_top.sv
module hit_timer_top
  import hit_timer_pkg::*;
#(
  parameter int CntW       = CNT_W,
  parameter int SyncStages = SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tickEn,
  input  logic            shutter,
  input  logic            modeCount,
  input  logic            hitIn,
  output logic [CntW-1:0] totVal,
  output logic [CntW-1:0] toaVal,
  output logic            hitFlag
);
  strobe_t strb;

  hit_timer_ctrl #(.SyncStages(SyncStages)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .shutter  (shutter),
    .modeCount(modeCount),
    .hitIn    (hitIn),
    .strb     (strb)
  );

  hit_timer_dp #(.CntW(CntW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .totVal (totVal),
    .toaVal (toaVal),
    .hitFlag(hitFlag)
  );
endmodule

// File: rtl/hit_timer_chk.sv
module hit_timer_chk #(
  parameter int CntW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            tickEn,
  input logic            shutter,
  input logic            modeCount,
  input logic [CntW-1:0] totVal,
  input logic [CntW-1:0] toaVal,
  input logic            hitFlag
);
  localparam logic [CntW-1:0] MaxVal = {CntW{1'b1}};

  a_r3_tot_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (totVal == MaxVal && !$rose(shutter)) |=> totVal == MaxVal);

  a_r3_toa_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (toaVal == MaxVal && !$rose(shutter)) |=> toaVal == MaxVal);

  a_r4_toa_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (toaVal != '0 && !$rose(shutter)) |=> toaVal >= $past(toaVal));

  a_r5_hold_closed: assert property (@(posedge clk) disable iff (!rstN)
    !shutter |=> ($stable(totVal) && $stable(toaVal) && $stable(hitFlag)));

  a_r6_tick_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !$rose(shutter)) |=> ($stable(totVal) && $stable(toaVal) && $stable(hitFlag)));

  a_r7_count_no_toa: assert property (@(posedge clk) disable iff (!rstN)
    (modeCount && toaVal == '0) |=> toaVal == '0);

  a_r8_flag_consistent: assert property (@(posedge clk) disable iff (!rstN)
    hitFlag == (totVal != '0 || toaVal != '0));

  a_r9_clear_on_open: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutter) |=> (totVal == '0 && toaVal == '0 && !hitFlag));
endmodule

bind hit_timer_top hit_timer_chk #(.CntW(CntW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .shutter  (shutter),
  .modeCount(modeCount),
  .totVal   (totVal),
  .toaVal   (toaVal),
  .hitFlag  (hitFlag)
);

// File: tb/tb_hit_timer_top.sv
module tb_hit_timer_top;
  localparam int ClkPeriod = 10;
  localparam int MaxCnt = 15;

  typedef struct packed {
    logic mode;
    int   delay;
    int   width;
    int   count;
    int   gap;
    int   len;
  } vec_t;

  localparam int NumVec = 8;
  localparam vec_t VECS [NumVec] = '{
    '{1'b0, 3, 4, 1, 2, 14},
    '{1'b0, 1, 3, 3, 2, 20},
    '{1'b0, 2, 20, 1, 2, 30},
    '{1'b0, 5, 1, 1, 2, 12},
    '{1'b1, 2, 2, 5, 2, 30},
    '{1'b1, 1, 1, 18, 2, 60},
    '{1'b0, 0, 0, 0, 2, 10},
    '{1'b0, 0, 2, 1, 2, 10}
  };

  logic clk = 1'b0;
  logic rstN, tickEn, shutter, modeCount, hitIn;
  logic [3:0] totVal, toaVal;
  logic hitFlag;
  int checks = 0;
  int errors = 0;

  hit_timer_top dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .shutter(shutter),
    .modeCount(modeCount), .hitIn(hitIn),
    .totVal(totVal), .toaVal(toaVal), .hitFlag(hitFlag)
  );

  always #(ClkPeriod/2) clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic inPulse(input int t, input vec_t v);
    int rel, period;
    if (t < v.delay || v.count == 0) return 1'b0;
    rel = t - v.delay;
    period = v.width + v.gap;
    return ((rel / period) < v.count) && ((rel % period) < v.width);
  endfunction

  function automatic int sat(input int x);
    return (x > MaxCnt) ? MaxCnt : x;
  endfunction

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic runVec(input vec_t v);
    modeCount = v.mode;
    idle(2);
    for (int t = 0; t < v.len; t++) begin
      shutter = 1'b1;
      hitIn = inPulse(t, v);
      @(negedge clk);
    end
    shutter = 1'b0;
    hitIn = 1'b0;
    idle(3);
  endtask

  initial begin
    #(ClkPeriod * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b1; shutter = 1'b0; modeCount = 1'b0; hitIn = 1'b0;
    idle(3);
    chk("R1 reset tot", totVal, 0);
    chk("R1 reset toa", toaVal, 0);
    chk("R1 reset flag", hitFlag, 0);
    rstN = 1'b1;
    idle(2);

    // Vector table: R2 R3 R4 R7 R8 R9 R10
    for (int i = 0; i < NumVec; i++) begin
      int eTot, eToa, eFlag;
      runVec(VECS[i]);
      eFlag = (VECS[i].count > 0) ? 1 : 0;
      if (VECS[i].mode) begin
        eTot = sat(VECS[i].count);
        eToa = 0;
      end else begin
        eTot = eFlag ? sat(VECS[i].width) : 0;
        eToa = eFlag ? sat(VECS[i].len - VECS[i].delay - 2) : 0;
      end
      chk($sformatf("R2/R3/R7 vec%0d tot", i), totVal, eTot);
      chk($sformatf("R4/R10/R7 vec%0d toa", i), toaVal, eToa);
      chk($sformatf("R8/R9 vec%0d flag", i), hitFlag, eFlag);
    end

    // R11: hit high across the window opening is not recorded
    modeCount = 1'b0;
    hitIn = 1'b1;
    idle(4);
    shutter = 1'b1;
    idle(8);
    shutter = 1'b0;
    idle(1);
    hitIn = 1'b0;
    idle(3);
    chk("R11 held hit tot", totVal, 0);
    chk("R11 held hit toa", toaVal, 0);
    chk("R11 held hit flag", hitFlag, 0);

    // R5: pulses with shutter low leave the frame untouched
    runVec(VECS[0]);
    hitIn = 1'b1;
    idle(4);
    hitIn = 1'b0;
    idle(4);
    hitIn = 1'b1;
    idle(2);
    hitIn = 1'b0;
    idle(4);
    chk("R5 hold tot", totVal, 4);
    chk("R5 hold toa", toaVal, 9);
    chk("R5 hold flag", hitFlag, 1);

    // R6: pulse hidden in tick-disabled cycles
    shutter = 1'b1;
    idle(1);
    tickEn = 1'b0;
    idle(1);
    hitIn = 1'b1;
    idle(4);
    hitIn = 1'b0;
    idle(2);
    tickEn = 1'b1;
    idle(5);
    shutter = 1'b0;
    idle(3);
    chk("R6 gated tot", totVal, 0);
    chk("R6 gated toa", toaVal, 0);
    chk("R6 gated flag", hitFlag, 0);

    // R1: asynchronous reset while holding data
    runVec(VECS[0]);
    chk("R1 pre-reset tot", totVal, 4);
    rstN = 1'b0;
    #1;
    chk("R1 async tot", totVal, 0);
    chk("R1 async toa", toaVal, 0);
    chk("R1 async flag", hitFlag, 0);
    idle(2);
    rstN = 1'b1;
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule